// File: doc/BRIEF.md
# Outstanding Load Tracking Table

This block sits between a load issue stage and a data cache that can hold several loads in flight at once. Each load handed to it takes the lowest-numbered free slot. The slot number goes to the cache as the transaction ID, and the load's metadata is stored in that slot: destination tag, access size, byte offset and sign-extend flag. The cache may answer in any order. Each answer carries the echoed ID, which selects the slot. The block then emits the stored metadata with the returned data in the same cycle and frees the slot.

The load issue side is a valid/ready stream. A load is accepted on a cycle where `ld_valid_i` and `ld_ready_o` are both high. `ld_ready_o` depends on the cache grant and on free space, and it is independent of `ld_valid_i`. The result stream has no back-pressure: the cache cannot be stalled, so `out_valid_o` is a one-cycle pulse in the cycle of the response, and the consumer must take it.

A flush empties the table. Loads still at the cache when the flush happens keep their slot reserved, with no output attached, until their late response arrives. That response is dropped silently, and only then can the slot be reused. This prevents a stale answer from being matched to a newer load.

Top module: `lt_table`

## Requirements
- R1: The ID width is max(1, ceil(log2(ENTRIES))). `cq_id_o` is the lowest-index free slot, and an accepted load is stored in that slot.
- R2: `ld_ready_o` is high only when a slot is free, `cq_gnt_i` is high and `flush_i` is low. `cq_req_o` is `ld_valid_i` while a slot is free and no flush is present. A load offered without a grant is not stored.
- R3: `full_o` is high when every slot is either in use or reserved by a flushed load. In that state, with no response arriving, `ld_ready_o` and `cq_req_o` stay low.
- R4: A response whose ID names an in-use slot raises `out_valid_o` in the same cycle. The outputs carry `rsp_data_i` and that slot's stored tag, size, offset and sign flag, and the slot is free from the next cycle.
- R5: Responses can complete in any order, and each one returns the metadata of the load that was given that ID.
- R6: If a response frees a slot in the same cycle that a load is offered, that slot counts as free. The new load can take it in that cycle, and the slot stays in use afterwards.
- R7: In a flush cycle no load is accepted and `out_valid_o` stays low. Slots in use become reserved. A later response to a reserved slot gives neither output nor error and frees it. Reserved slots are not handed out again before that response.
- R8: A response to a slot that is neither in use nor reserved sets `err_o` in that cycle with `out_valid_o` low. It leaves every slot unchanged.
- R9: After reset all slots are free, `full_o`, `out_valid_o` and `err_o` are low, and `cq_id_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Drop every load in flight |
| ld_valid_i | input | 1 | Load offered |
| ld_ready_o | output | 1 | Load can be accepted this cycle |
| ld_tag_i | input | TAG_W | Destination tag of the offered load |
| ld_size_i | input | SIZE_W | Access size code |
| ld_off_i | input | OFF_W | Byte offset within the word |
| ld_sext_i | input | 1 | Sign-extend the result |
| cq_req_o | output | 1 | Request to the cache |
| cq_gnt_i | input | 1 | Cache grant |
| cq_id_o | output | IDW | Transaction ID sent with the request |
| rsp_valid_i | input | 1 | Cache response present |
| rsp_id_i | input | IDW | Echoed transaction ID |
| rsp_data_i | input | DATA_W | Response data |
| out_valid_o | output | 1 | Completed load this cycle |
| out_data_o | output | DATA_W | Completed load data |
| out_tag_o | output | TAG_W | Stored destination tag |
| out_size_o | output | SIZE_W | Stored size code |
| out_off_o | output | OFF_W | Stored byte offset |
| out_sext_o | output | 1 | Stored sign-extend flag |
| full_o | output | 1 | No slot available |
| err_o | output | 1 | Response to an unknown ID |

## Verification
The hardest case to reach is a stale response that returns after a flush while newer loads already occupy the other slots. A wrong design would then attach new metadata to old data or hand the reserved slot out again.

The stimulus fills every slot and flushes while the table is full. It then returns the stale IDs one at a time, interleaved with fresh issues. After each stale return it checks which ID the next load receives, and it checks that only the fresh loads produce results. A cycle in which one slot is released and reused at once is reached by driving a response and an offered load together while the table is full.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int DEF_ENTRIES = 2;
  localparam int DEF_TAG_W   = 5;
  localparam int DEF_SIZE_W  = 2;
  localparam int DEF_OFF_W   = 3;
  localparam int DEF_DATA_W  = 64;

  function automatic int id_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  typedef enum logic [1:0] {
    RSP_IDLE,
    RSP_DELIVER,
    RSP_DROP,
    RSP_BAD
  } rsp_kind_e;
endpackage

// File: rtl/lt_pick.sv
module lt_pick #(
  parameter int N   = 2,
  parameter int IDW = 1
) (
  input  logic [N-1:0]   req_i,
  output logic           any_o,
  output logic [IDW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/lt_slot_state.sv
module lt_slot_state
  import lt_pkg::*;
#(
  parameter int N   = 2,
  parameter int IDW = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           flush_i,
  input  logic           alloc_i,
  input  logic [IDW-1:0] alloc_idx_i,
  input  logic           rsp_valid_i,
  input  logic [IDW-1:0] rsp_id_i,
  output logic [N-1:0]   free_o,
  output logic           full_o,
  output rsp_kind_e      kind_o
);
  logic [N-1:0] live_q, orph_q, hit, busy, rel;
  logic sel_live, sel_orph;

  assign busy = live_q | orph_q;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign hit[i] = rsp_valid_i && (rsp_id_i == IDW'(i));
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        live_q[i] <= 1'b0;
        orph_q[i] <= 1'b0;
      end else if (flush_i) begin
        live_q[i] <= 1'b0;
        orph_q[i] <= busy[i] & ~hit[i];
      end else begin
        live_q[i] <= (live_q[i] & ~hit[i]) | (alloc_i && alloc_idx_i == IDW'(i));
        orph_q[i] <= orph_q[i] & ~hit[i];
      end
    end
  end

  assign rel      = hit & busy;
  assign free_o   = ~busy | rel;
  assign full_o   = &busy;
  assign sel_live = |(hit & live_q);
  assign sel_orph = |(hit & orph_q);

  always_comb begin
    if (!rsp_valid_i)                kind_o = RSP_IDLE;
    else if (sel_live && !flush_i)   kind_o = RSP_DELIVER;
    else if (sel_live || sel_orph)   kind_o = RSP_DROP;
    else                             kind_o = RSP_BAD;
  end
endmodule

// File: rtl/lt_meta_store.sv
module lt_meta_store #(
  parameter int N   = 2,
  parameter int IDW = 1,
  parameter int W   = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [IDW-1:0] wr_idx_i,
  input  logic [W-1:0]   wr_data_i,
  input  logic [IDW-1:0] rd_idx_i,
  output logic [W-1:0]   rd_data_o
);
  logic [W-1:0] mem [N];

  for (genvar i = 0; i < N; i++) begin : g_row
    always_ff @(posedge clk_i) begin
      if (!rst_ni)                                  mem[i] <= '0;
      else if (wr_en_i && wr_idx_i == IDW'(i))      mem[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_idx_i == IDW'(i)) rd_data_o = mem[i];
    end
  end
endmodule

// File: rtl/lt_table.sv
module lt_table
  import lt_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int TAG_W   = DEF_TAG_W,
  parameter int SIZE_W  = DEF_SIZE_W,
  parameter int OFF_W   = DEF_OFF_W,
  parameter int DATA_W  = DEF_DATA_W,
  localparam int IDW    = id_w(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              ld_valid_i,
  output logic              ld_ready_o,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  input  logic [OFF_W-1:0]  ld_off_i,
  input  logic              ld_sext_i,
  output logic              cq_req_o,
  input  logic              cq_gnt_i,
  output logic [IDW-1:0]    cq_id_o,
  input  logic              rsp_valid_i,
  input  logic [IDW-1:0]    rsp_id_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [SIZE_W-1:0] out_size_o,
  output logic [OFF_W-1:0]  out_off_o,
  output logic              out_sext_o,
  output logic              full_o,
  output logic              err_o
);
  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [SIZE_W-1:0] size;
    logic [OFF_W-1:0]  off;
    logic              sext;
  } meta_t;
  localparam int MW = $bits(meta_t);

  logic [ENTRIES-1:0] free_vec;
  logic               any_free, accept;
  logic [IDW-1:0]     pick_idx;
  rsp_kind_e          kind;
  meta_t              wr_meta, rd_meta;

  lt_pick #(.N(ENTRIES), .IDW(IDW)) u_pick (
    .req_i (free_vec),
    .any_o (any_free),
    .idx_o (pick_idx)
  );

  assign ld_ready_o = any_free && cq_gnt_i && !flush_i;
  assign cq_req_o   = ld_valid_i && any_free && !flush_i;
  assign cq_id_o    = pick_idx;
  assign accept     = ld_valid_i && ld_ready_o;

  lt_slot_state #(.N(ENTRIES), .IDW(IDW)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .alloc_i     (accept),
    .alloc_idx_i (pick_idx),
    .rsp_valid_i (rsp_valid_i),
    .rsp_id_i    (rsp_id_i),
    .free_o      (free_vec),
    .full_o      (full_o),
    .kind_o      (kind)
  );

  assign wr_meta = '{tag: ld_tag_i, size: ld_size_i, off: ld_off_i, sext: ld_sext_i};

  lt_meta_store #(.N(ENTRIES), .IDW(IDW), .W(MW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (accept),
    .wr_idx_i  (pick_idx),
    .wr_data_i (wr_meta),
    .rd_idx_i  (rsp_id_i),
    .rd_data_o (rd_meta)
  );

  assign out_valid_o = (kind == RSP_DELIVER);
  assign err_o       = (kind == RSP_BAD);
  assign out_data_o  = rsp_data_i;
  assign out_tag_o   = rd_meta.tag;
  assign out_size_o  = rd_meta.size;
  assign out_off_o   = rd_meta.off;
  assign out_sext_o  = rd_meta.sext;
endmodule

// File: rtl/lt_table_chk.sv
module lt_table_chk #(
  parameter int ENTRIES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic flush_i,
  input logic ld_valid_i,
  input logic ld_ready_o,
  input logic cq_req_o,
  input logic cq_gnt_i,
  input logic rsp_valid_i,
  input logic out_valid_o,
  input logic full_o,
  input logic err_o
);
  AST_READY_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ready_o |-> cq_gnt_i && !flush_i);  // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !rsp_valid_i |-> !ld_ready_o && !cq_req_o);  // R3
  AST_OUT_ON_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> rsp_valid_i);  // R4
  AST_FLUSH_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !out_valid_o && !ld_ready_o);  // R7
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rsp_valid_i && !out_valid_o);  // R8
  AST_ERR_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !(ld_valid_i && ld_ready_o) && !flush_i |=> full_o == $past(full_o));  // R8
  AST_RESET_EMPTY: assert property (@(posedge clk_i)
    !rst_ni |=> !full_o);  // R9
  AST_ENTRIES_SANE: assert final (ENTRIES >= 1);  // R1
endmodule

bind lt_table lt_table_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/lt_table_test.sv
module lt_table_test;
  localparam int N   = 2;
  localparam int IDW = lt_pkg::id_w(N);

  logic clk = 0, rst_n = 0, flush = 0;
  logic ld_valid = 0, ld_sext = 0, cq_gnt = 0, rsp_valid = 0;
  logic [4:0] ld_tag = 0;
  logic [1:0] ld_size = 0;
  logic [2:0] ld_off = 0;
  logic [IDW-1:0] rsp_id = 0;
  logic [63:0] rsp_data = 0;
  logic ld_ready_o, cq_req_o, out_valid_o, out_sext_o, full_o, err_o;
  logic [IDW-1:0] cq_id_o;
  logic [63:0] out_data_o;
  logic [4:0] out_tag_o;
  logic [1:0] out_size_o;
  logic [2:0] out_off_o;

  always #2 clk = ~clk;

  lt_table #(.ENTRIES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .ld_valid_i(ld_valid), .ld_ready_o(ld_ready_o), .ld_tag_i(ld_tag),
    .ld_size_i(ld_size), .ld_off_i(ld_off), .ld_sext_i(ld_sext),
    .cq_req_o(cq_req_o), .cq_gnt_i(cq_gnt), .cq_id_o(cq_id_o),
    .rsp_valid_i(rsp_valid), .rsp_id_i(rsp_id), .rsp_data_i(rsp_data),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_tag_o(out_tag_o),
    .out_size_o(out_size_o), .out_off_o(out_off_o), .out_sext_o(out_sext_o),
    .full_o(full_o), .err_o(err_o)
  );

  // cache-side model: ID captured at grant, cleared by reset
  logic [IDW-1:0] lat_id;
  always_ff @(posedge clk) begin
    if (!rst_n) lat_id <= '0;
    else if (cq_req_o && cq_gnt) lat_id <= cq_id_o;
  end

  typedef struct packed {
    logic [63:0] d;
    logic [4:0]  tag;
    logic [1:0]  sz;
    logic [2:0]  off;
    logic        sx;
  } exp_t;

  exp_t  exp_q[$];
  string lbl_q[$];
  exp_t  slot_meta [N];
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input string r, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // monitor: compares every delivered result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      exp_t got;
      got = '{d: out_data_o, tag: out_tag_o, sz: out_size_o, off: out_off_o, sx: out_sext_o};
      if (exp_q.size() == 0) begin
        chk("R4 unexpected result", 1, 0);
      end else begin
        exp_t e;
        string l;
        e = exp_q.pop_front();
        l = lbl_q.pop_front();
        checks++;
        if (got != e) begin
          failures++;
          $display("FAIL %s result actual=%h expected=%h", l, got, e);
        end
      end
    end
  end

  task automatic issue(input logic [4:0] tg, input logic [1:0] sz, input logic [2:0] of,
                       input logic sx, input int exp_id, input string r);
    ld_valid = 1; cq_gnt = 1;
    ld_tag = tg; ld_size = sz; ld_off = of; ld_sext = sx;
    @(negedge clk);
    chk({r, " ready"}, ld_ready_o, 1);
    chk({r, " id"}, cq_id_o, exp_id);
    slot_meta[exp_id] = '{d: '0, tag: tg, sz: sz, off: of, sx: sx};
    @(posedge clk); #1;
    ld_valid = 0; cq_gnt = 0;
  endtask

  task automatic respond(input int id, input logic [63:0] d, input bit exp_out,
                         input bit exp_err, input string r);
    rsp_valid = 1; rsp_id = IDW'(id); rsp_data = d;
    if (exp_out) begin
      exp_t e;
      e = slot_meta[id];
      e.d = d;
      exp_q.push_back(e);
      lbl_q.push_back(r);
    end
    @(negedge clk);
    chk({r, " out_valid"}, out_valid_o, exp_out);
    chk({r, " err"}, err_o, exp_err);
    @(posedge clk); #1;
    rsp_valid = 0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 full", full_o, 0);
    chk("R9 out_valid", out_valid_o, 0);
    chk("R9 err", err_o, 0);
    chk("R9 id", cq_id_o, 0);
    @(posedge clk); #1;

    // R1 lowest free first
    issue(5'h03, 2'd2, 3'd4, 1'b1, 0, "R1 first");
    issue(5'h11, 2'd1, 3'd2, 1'b0, 1, "R1 second");
    // R3 full blocks issue
    ld_valid = 1; cq_gnt = 1;
    @(negedge clk);
    chk("R3 full", full_o, 1);
    chk("R3 ready", ld_ready_o, 0);
    chk("R3 req", cq_req_o, 0);
    @(posedge clk); #1;
    ld_valid = 0; cq_gnt = 0;

    // R5 out of order: newest first via latched ID
    chk("R5 latched id", lat_id, 1);
    respond(int'(lat_id), 64'hB0B0_0000_1111_2222, 1, 0, "R5 late-issued first");
    respond(0, 64'hA0A0_3333_4444_5555, 1, 0, "R4 earlier load");
    @(negedge clk);
    chk("R4 freed", full_o, 0);
    @(posedge clk); #1;

    // R8 unknown ID
    respond(0, 64'hDEAD, 0, 1, "R8 stray");
    @(negedge clk);
    chk("R8 full unchanged", full_o, 0);
    @(posedge clk); #1;
    issue(5'h07, 2'd3, 3'd0, 1'b1, 0, "R8 table unchanged");

    // R2 no grant, nothing stored
    ld_valid = 1; cq_gnt = 0; ld_tag = 5'h1F;
    @(negedge clk);
    chk("R2 ready w/o gnt", ld_ready_o, 0);
    chk("R2 req w/o gnt", cq_req_o, 1);
    @(posedge clk); #1;
    ld_valid = 0;
    issue(5'h0C, 2'd0, 3'd7, 1'b0, 1, "R2 next id after refused");

    // R6 release and reuse in one cycle
    rsp_valid = 1; rsp_id = 0; rsp_data = 64'hC0C0_0000_0000_0001;
    begin
      exp_t e;
      e = slot_meta[0];
      e.d = rsp_data;
      exp_q.push_back(e);
      lbl_q.push_back("R6 released load");
    end
    ld_valid = 1; cq_gnt = 1; ld_tag = 5'h15; ld_size = 2'd1; ld_off = 3'd6; ld_sext = 1;
    @(negedge clk);
    chk("R6 ready", ld_ready_o, 1);
    chk("R6 id", cq_id_o, 0);
    chk("R6 out_valid", out_valid_o, 1);
    slot_meta[0] = '{d: '0, tag: 5'h15, sz: 2'd1, off: 3'd6, sx: 1'b1};
    @(posedge clk); #1;
    rsp_valid = 0; ld_valid = 0; cq_gnt = 0;
    @(negedge clk);
    chk("R6 still full", full_o, 1);
    @(posedge clk); #1;
    respond(1, 64'hD0D0_0000_0000_0002, 1, 0, "R5 older slot");
    respond(0, 64'hE0E0_0000_0000_0003, 1, 0, "R6 reused slot");

    // R7 flush while full
    issue(5'h01, 2'd2, 3'd1, 1'b0, 0, "R7 pre-flush a");
    issue(5'h02, 2'd2, 3'd3, 1'b1, 1, "R7 pre-flush b");
    flush = 1; ld_valid = 1; cq_gnt = 1;
    @(negedge clk);
    chk("R7 ready in flush", ld_ready_o, 0);
    chk("R7 out in flush", out_valid_o, 0);
    @(posedge clk); #1;
    flush = 0; ld_valid = 0; cq_gnt = 0;
    @(negedge clk);
    chk("R7 reserved full", full_o, 1);
    @(posedge clk); #1;
    respond(1, 64'h5151, 0, 0, "R7 stale b");
    issue(5'h0A, 2'd0, 3'd2, 1'b1, 1, "R7 reuse only drained slot");
    respond(0, 64'h5050, 0, 0, "R7 stale a");
    issue(5'h0B, 2'd3, 3'd5, 1'b0, 0, "R7 reuse second drained slot");
    respond(1, 64'h6161_0000, 1, 0, "R7 fresh b");
    respond(0, 64'h6060_0000, 1, 0, "R7 fresh a");

    @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule